// File: doc/BRIEF.md
# Command-Driven AXI4 Single-Beat Sequencer

This block turns a queue of already-decoded commands into AXI4 master transactions, one 64-bit transfer per command. Each command names an operation (store or load-and-compare), a base address, an offset and two 32-bit data halves. The block adds base and offset to form the target address and joins the halves into one 64-bit word. That word is either written out or, for a load-and-compare, used as the value the returned read data must equal.

Commands enter through a valid/ready port backed by a small FIFO. The producer may present a command at any time. The command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_valid` is high and `cmd_ready` is low, the producer holds every command field steady. `cmd_ready` drops only when the FIFO is full. The engine pulls commands in arrival order and keeps exactly one transaction on the bus at a time. It issues the next command only after the write response or read data handshake of the current one. Each load-and-compare ends with a one-cycle pass pulse, or with a sticky fail flag and a step of a 16-bit error counter. An `idle` output tells a test environment when all queued work is done.

Top module: `axi_cmd_seq`

## Requirements
- R1: The address on `m_awaddr` / `m_araddr` equals `cmd_base + cmd_offset`, taken modulo 2^32 (a carry out of bit 31 is dropped).
- R2: Write data on `m_wdata` is `{cmd_hi, cmd_lo}`: `cmd_hi` sits in bits 63:32 and `cmd_lo` in bits 31:0. `m_wstrb` is 8'hFF.
- R3: Every transfer is a single beat. AxLEN is 0, AxSIZE is 3'b011 (8 bytes), AxBURST is 2'b01 (INCR) and `m_wlast` is 1.
- R4: `cmd_op` = 0 produces a write (AW and W channels); `cmd_op` = 1 produces a read on the AR channel followed by a compare.
- R5: Transactions leave the block in the order in which their commands were accepted on the command port.
- R6: At most one transaction is outstanding. No AW or AR request starts before the B handshake (write) or R handshake (read) of the previous command. A raised AWVALID or ARVALID stays high with a stable address until its handshake.
- R7: The command FIFO holds `FIFO_DEPTH` (default 4) entries. `cmd_ready` is low exactly when the FIFO is full. With the bus stalled, five commands are accepted (one in the engine, four queued) and `cmd_ready` is then low.
- R8: A read whose 64 returned bits equal `{cmd_hi, cmd_lo}` and whose RRESP is OKAY (2'b00) raises `check_pass` for exactly one cycle, the cycle after the R handshake. `err_count` is unchanged in that case.
- R9: A read whose data differs from the expected word in any bit sets `check_fail` and adds one to `err_count`. `check_fail` stays set until reset, even after later passing reads.
- R10: A read with RRESP other than OKAY counts as a failure (R9 behaviour) even when the data matches.
- R11: `idle` is high exactly when the FIFO is empty and no transaction is in progress. While `idle` is high, no VALID output to the bus is raised.
- R12: After reset `idle` = 1, `cmd_ready` = 1, all bus VALID outputs are 0, `check_pass` = 0, `check_fail` = 0 and `err_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command FIFO has room |
| cmd_op | input | 1 | 0 = write, 1 = read-and-compare |
| cmd_base | input | 32 | Base address |
| cmd_offset | input | 32 | Offset added to base |
| cmd_hi | input | 32 | Upper data half |
| cmd_lo | input | 32 | Lower data half |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Burst length (0) |
| m_awsize | output | 3 | Beat size (3) |
| m_awburst | output | 2 | Burst type (INCR) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Byte strobes |
| m_wlast | output | 1 | Last beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Burst length (0) |
| m_arsize | output | 3 | Beat size (3) |
| m_arburst | output | 2 | Burst type (INCR) |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | 64 | Read data |
| m_rresp | input | 2 | Read response |
| check_pass | output | 1 | One-cycle pulse on a matching read |
| check_fail | output | 1 | Sticky mismatch flag |
| err_count | output | 16 | Number of failed reads |
| idle | output | 1 | No queued or active work |

## Verification
A table of eight commands runs against a memory-model slave. The writes cover distinct addresses, one of them with a base+offset sum that wraps past 2^32. These show whether the address adder and the data-half placement are correct. The reads cover matching words and one word that differs in a single low bit, which separates a full 64-bit compare from a partial one. Directed runs stall every bus ready line to fill the FIFO and check arrival order. They also return an error response with correct data, check that the fail flag survives a later pass, and reset the status.

// File: rtl/axi_cmd_seq_pkg.sv
package axi_cmd_seq_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int STRB_W = DATA_W / 8;
  localparam int SIZE_CODE = $clog2(STRB_W);

  typedef struct packed {
    logic              op;     // 0 write, 1 read-and-compare
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WADDR = 3'd1,
    ST_WRESP = 3'd2,
    ST_RADDR = 3'd3,
    ST_RDATA = 3'd4
  } eng_state_t;
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the queue never holds more than DEPTH entries
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R7: an empty queue is never popped
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/axi_seq_engine.sv
module axi_seq_engine
  import axi_cmd_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              head,
  input  logic              q_empty,
  output logic              pop,
  output logic              busy,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  input  logic              bvalid,
  output logic              bready,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  input  logic              rvalid,
  output logic              rready,
  output logic              rsp_fire,
  output logic [DATA_W-1:0] expect_word
);
  eng_state_t        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic              aw_pend, w_pend;
  logic              aw_left, w_left;

  assign pop         = (state == ST_IDLE) && !q_empty;
  assign busy        = (state != ST_IDLE);
  assign awvalid     = (state == ST_WADDR) && aw_pend;
  assign wvalid      = (state == ST_WADDR) && w_pend;
  assign bready      = (state == ST_WRESP);
  assign arvalid     = (state == ST_RADDR);
  assign rready      = (state == ST_RDATA);
  assign awaddr      = cur_addr;
  assign araddr      = cur_addr;
  assign wdata       = cur_data;
  assign expect_word = cur_data;
  assign rsp_fire    = rready && rvalid;
  assign aw_left     = aw_pend && !awready;
  assign w_left      = w_pend && !wready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      cur_data <= '0;
      aw_pend  <= 1'b0;
      w_pend   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (pop) begin
          cur_addr <= head.base + head.off;
          cur_data <= {head.hi, head.lo};
          if (head.op) begin
            state <= ST_RADDR;
          end else begin
            state   <= ST_WADDR;
            aw_pend <= 1'b1;
            w_pend  <= 1'b1;
          end
        end
        ST_WADDR: begin
          aw_pend <= aw_left;
          w_pend  <= w_left;
          if (!aw_left && !w_left) state <= ST_WRESP;
        end
        ST_WRESP: if (bvalid) state <= ST_IDLE;
        ST_RADDR: if (arready) state <= ST_RDATA;
        ST_RDATA: if (rvalid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R6: reads and writes never overlap on the bus
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((awvalid || wvalid || bready) && (arvalid || rready)));
  // R6: address request held steady until accepted
  p_aw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));
  p_ar_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));
  // R6: no new command is taken while a response is awaited
  p_no_pop_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bready || rready) |-> !pop);
endmodule

// File: rtl/read_checker.sv
module read_checker #(
  parameter int DW    = 64,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_fire,
  input  logic [DW-1:0]    got_word,
  input  logic [1:0]       got_resp,
  input  logic [DW-1:0]    want_word,
  output logic             pass_pulse,
  output logic             fail_flag,
  output logic [ERR_W-1:0] err_total
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic bad;
  assign bad = (got_word != want_word) || (got_resp != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_pulse <= 1'b0;
      fail_flag  <= 1'b0;
      err_total  <= '0;
    end else begin
      pass_pulse <= rsp_fire && !bad;
      if (rsp_fire && bad) begin
        fail_flag <= 1'b1;
        if (err_total != ERR_MAX) err_total <= err_total + 1'b1;
      end
    end
  end

  // R9: the fail flag never clears outside reset
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |=> fail_flag);
  // R8: a pass is a single-cycle pulse
  p_pass_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |=> !pass_pulse);
  // R9: the error count moves by at most one per cycle
  p_err_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_total == $past(err_total)) || (err_total == $past(err_total) + 1'b1));
  // R8: a pass never coincides with a count step
  p_pass_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> (err_total == $past(err_total)));
endmodule

// File: rtl/axi_cmd_seq.sv
module axi_cmd_seq
  import axi_cmd_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int ERR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_offset,
  input  logic [HALF_W-1:0] cmd_hi,
  input  logic [HALF_W-1:0] cmd_lo,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  output logic              check_pass,
  output logic              check_fail,
  output logic [ERR_W-1:0]  err_count,
  output logic              idle
);
  cmd_t              in_cmd, head;
  logic              q_full, q_empty, pop, busy, rsp_fire, push;
  logic [DATA_W-1:0] expect_word;

  assign in_cmd    = '{op: cmd_op, base: cmd_base, off: cmd_offset, hi: cmd_hi, lo: cmd_lo};
  assign cmd_ready = !q_full;
  assign push      = cmd_valid && !q_full;
  assign idle      = q_empty && !busy;

  assign m_awlen   = 8'd0;
  assign m_arlen   = 8'd0;
  assign m_awsize  = 3'(SIZE_CODE);
  assign m_arsize  = 3'(SIZE_CODE);
  assign m_awburst = 2'b01;
  assign m_arburst = 2'b01;
  assign m_wstrb   = '1;
  assign m_wlast   = 1'b1;

  cmd_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk, .rst_n, .push, .push_data(in_cmd), .pop, .head,
    .full(q_full), .empty(q_empty)
  );

  axi_seq_engine u_eng (
    .clk, .rst_n, .head, .q_empty, .pop, .busy,
    .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr),
    .wvalid(m_wvalid), .wready(m_wready), .wdata(m_wdata),
    .bvalid(m_bvalid), .bready(m_bready),
    .arvalid(m_arvalid), .arready(m_arready), .araddr(m_araddr),
    .rvalid(m_rvalid), .rready(m_rready),
    .rsp_fire, .expect_word
  );

  read_checker #(.DW(DATA_W), .ERR_W(ERR_W)) u_chk (
    .clk, .rst_n, .rsp_fire, .got_word(m_rdata), .got_resp(m_rresp),
    .want_word(expect_word), .pass_pulse(check_pass),
    .fail_flag(check_fail), .err_total(err_count)
  );

  // R11: an idle block drives no request to the bus
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !(m_awvalid || m_wvalid || m_arvalid || m_bready || m_rready));
  // R7: ready is withdrawn only when full
  p_ready_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> !q_empty);
endmodule

// File: tb/tb_axi_cmd_seq.sv
module tb_axi_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [31:0] cmd_base = '0, cmd_offset = '0, cmd_hi = '0, cmd_lo = '0;
  logic        cmd_ready;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic        arvalid, arready, rvalid, rready, wlast;
  logic [31:0] awaddr, araddr;
  logic [7:0]  awlen, arlen, wstrb;
  logic [2:0]  awsize, arsize;
  logic [1:0]  awburst, arburst, rresp;
  logic [63:0] wdata, rdata;
  logic        check_pass, check_fail, idle;
  logic [15:0] err_count;

  axi_cmd_seq dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_base, .cmd_offset,
    .cmd_hi, .cmd_lo,
    .m_awvalid(awvalid), .m_awready(awready), .m_awaddr(awaddr), .m_awlen(awlen),
    .m_awsize(awsize), .m_awburst(awburst), .m_wvalid(wvalid), .m_wready(wready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wlast(wlast), .m_bvalid(bvalid),
    .m_bready(bready), .m_arvalid(arvalid), .m_arready(arready), .m_araddr(araddr),
    .m_arlen(arlen), .m_arsize(arsize), .m_arburst(arburst), .m_rvalid(rvalid),
    .m_rready(rready), .m_rdata(rdata), .m_rresp(rresp),
    .check_pass, .check_fail, .err_count, .idle
  );

  // ---------------- memory-model slave ----------------
  logic        slv_hold = 1'b0, slv_err = 1'b0, tog;
  logic        got_aw, got_w;
  logic [31:0] hold_aw, last_awaddr, last_araddr;
  logic [63:0] hold_w, last_wdata;
  logic [7:0]  last_wstrb, last_awlen;
  logic [2:0]  last_awsize;
  logic [1:0]  last_awburst;
  logic        last_wlast;
  logic [63:0] mem [16];
  logic [32:0] oplog [32];
  int          nlog, pass_cnt, overlap;

  assign awready = !slv_hold && !got_aw && tog;
  assign wready  = !slv_hold && !got_w;
  assign arready = !slv_hold && !rvalid && tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog <= 1'b0; got_aw <= 1'b0; got_w <= 1'b0; bvalid <= 1'b0;
      rvalid <= 1'b0; rdata <= '0; rresp <= '0; nlog <= 0; pass_cnt <= 0; overlap <= 0;
      hold_aw <= '0; hold_w <= '0;
    end else begin
      tog <= ~tog;
      if (check_pass) pass_cnt <= pass_cnt + 1;
      if ((arvalid && (got_aw || bvalid)) || (awvalid && rvalid)) overlap <= overlap + 1;
      if (awvalid && awready) begin
        got_aw <= 1'b1; hold_aw <= awaddr; last_awaddr <= awaddr;
        last_awlen <= awlen; last_awsize <= awsize; last_awburst <= awburst;
        oplog[nlog] <= {1'b0, awaddr}; nlog <= nlog + 1;
      end
      if (wvalid && wready) begin
        got_w <= 1'b1; hold_w <= wdata; last_wdata <= wdata;
        last_wstrb <= wstrb; last_wlast <= wlast;
      end
      if (got_aw && got_w && !bvalid) begin
        mem[hold_aw[6:3]] <= hold_w; bvalid <= 1'b1; got_aw <= 1'b0; got_w <= 1'b0;
      end
      if (bvalid && bready) bvalid <= 1'b0;
      if (rvalid && rready) rvalid <= 1'b0;
      if (arvalid && arready) begin
        rvalid <= 1'b1; rdata <= mem[araddr[6:3]]; rresp <= slv_err ? 2'b10 : 2'b00;
        last_araddr <= araddr; oplog[nlog] <= {1'b1, araddr}; nlog <= nlog + 1;
      end
    end
  end

  // ---------------- checking helpers ----------------
  int total = 0, bad = 0;
  logic [63:0] shadow [16];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic op, input logic [31:0] b, o, h, l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_base = b; cmd_offset = o; cmd_hi = h; cmd_lo = l;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!idle) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // {op, base, offset, hi, lo}
  localparam logic [128:0] VEC [8] = '{
    {1'b0, 32'h0000_0000, 32'h0000_0008, 32'hA0A1_A2A3, 32'hB0B1_B2B3},
    {1'b0, 32'h0000_0040, 32'h0000_0010, 32'h1122_3344, 32'h5566_7788},
    {1'b1, 32'h0000_0000, 32'h0000_0008, 32'hA0A1_A2A3, 32'hB0B1_B2B3},
    {1'b1, 32'h0000_0040, 32'h0000_0010, 32'h1122_3344, 32'h5566_7788},
    {1'b1, 32'h0000_0040, 32'h0000_0010, 32'h1122_3344, 32'h5566_7789},
    {1'b0, 32'hFFFF_FFF8, 32'h0000_0020, 32'hDEAD_BEEF, 32'h0BAD_F00D},
    {1'b1, 32'h0000_0010, 32'h0000_0008, 32'hDEAD_BEEF, 32'h0BAD_F00D},
    {1'b0, 32'h0000_0030, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [128:0] v;
    logic [31:0]  a;
    logic [63:0]  w;
    int p0, e0, n0;
    logic fail_seen;
    fail_seen = 1'b0;
    for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 idle", 64'(idle), 64'd1);
    check("R12 cmd_ready", 64'(cmd_ready), 64'd1);
    check("R12 valids", 64'({awvalid, wvalid, arvalid}), 64'd0);
    check("R12 status", 64'({check_pass, check_fail, err_count}), 64'd0);

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      a = v[127:96] + v[95:64];
      w = v[63:0];
      p0 = pass_cnt; e0 = int'(err_count); n0 = nlog;
      push(v[128], v[127:96], v[95:64], v[63:32], v[31:0]);
      wait_idle();
      check("R4 opcode selects channel", 64'(oplog[n0][32]), 64'(v[128]));
      check("R5 one transaction per command", 64'(nlog - n0), 64'd1);
      if (!v[128]) begin
        shadow[a[6:3]] = w;
        check("R1 write address", 64'(last_awaddr), 64'(a));
        check("R2 write data", last_wdata, w);
        check("R2 strobes", 64'(last_wstrb), 64'hFF);
        check("R3 aw attrs", 64'({last_awlen, last_awsize, last_awburst, last_wlast}),
              64'({8'd0, 3'd3, 2'b01, 1'b1}));
      end else begin
        check("R1 read address", 64'(last_araddr), 64'(a));
        check("R3 ar attrs", 64'({arlen, arsize, arburst}), 64'({8'd0, 3'd3, 2'b01}));
        if (shadow[a[6:3]] == w) begin
          check("R8 pass pulse", 64'(pass_cnt - p0), 64'd1);
          check("R8 no count", 64'(int'(err_count) - e0), 64'd0);
        end else begin
          fail_seen = 1'b1;
          check("R9 no pass on mismatch", 64'(pass_cnt - p0), 64'd0);
          check("R9 count step", 64'(int'(err_count) - e0), 64'd1);
        end
        check("R9 fail flag", 64'(check_fail), 64'(fail_seen));
      end
      check("R11 idle after work", 64'(idle), 64'd1);
    end

    // R10: error response with matching data
    slv_err = 1'b1;
    p0 = pass_cnt; e0 = int'(err_count);
    push(1'b1, 32'h0, 32'h8, 32'hA0A1_A2A3, 32'hB0B1_B2B3);
    wait_idle();
    check("R10 no pass on SLVERR", 64'(pass_cnt - p0), 64'd0);
    check("R10 count step", 64'(int'(err_count) - e0), 64'd1);
    slv_err = 1'b0;

    // R9 sticky after a later pass
    p0 = pass_cnt;
    push(1'b1, 32'h0, 32'h8, 32'hA0A1_A2A3, 32'hB0B1_B2B3);
    wait_idle();
    check("R9 later pass seen", 64'(pass_cnt - p0), 64'd1);
    check("R9 fail sticky", 64'(check_fail), 64'd1);

    // R7 / R5 / R6: stall the bus, fill the queue, then release
    slv_hold = 1'b1;
    n0 = nlog;
    push(1'b0, 32'h0, 32'h40, 32'h0000_0001, 32'h0000_0002);
    push(1'b0, 32'h0, 32'h48, 32'h0000_0003, 32'h0000_0004);
    push(1'b1, 32'h0, 32'h40, 32'h0000_0001, 32'h0000_0002);
    push(1'b1, 32'h20, 32'h28, 32'h0000_0003, 32'h0000_0004);
    push(1'b0, 32'h50, 32'h8, 32'h0000_0005, 32'h0000_0006);
    @(negedge clk);
    check("R7 ready low when full", 64'(cmd_ready), 64'd0);
    check("R11 not idle with queue", 64'(idle), 64'd0);
    check("R6 aw held while stalled", 64'({awvalid, awaddr}), 64'({1'b1, 32'h40}));
    p0 = pass_cnt;
    slv_hold = 1'b0;
    wait_idle();
    check("R5 count", 64'(nlog - n0), 64'd5);
    check("R5 order 0", 64'(oplog[n0]),     64'({1'b0, 32'h40}));
    check("R5 order 1", 64'(oplog[n0 + 1]), 64'({1'b0, 32'h48}));
    check("R5 order 2", 64'(oplog[n0 + 2]), 64'({1'b1, 32'h40}));
    check("R5 order 3", 64'(oplog[n0 + 3]), 64'({1'b1, 32'h48}));
    check("R5 order 4", 64'(oplog[n0 + 4]), 64'({1'b0, 32'h58}));
    check("R8 queued reads pass", 64'(pass_cnt - p0), 64'd2);
    check("R6 no overlap", 64'(overlap), 64'd0);

    // R12 reset clears status
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R12 status after reset", 64'({check_fail, err_count}), 64'd0);
    check("R12 idle after reset", 64'({idle, cmd_ready}), 64'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule